// File: doc/BRIEF.md
# Multiplexed-Bus Reprogrammable Byte Memory

This block is a synthesizable behavioural model of a byte-wide, electrically erasable read-only memory whose low address byte and data share one 8-bit bus. A host puts the low address on the bus and drops the address strobe `ale`. The block captures the byte, and the same bus then returns the stored byte while the output-enable `oe_n` is low. The programming and erase voltages are reduced to three digital qualifiers: `vpp_hi` for the high voltage on the output-enable pin, `vdd_hi` for the raised supply and `a9_hv` for the high voltage on address bit 9. The bidirectional bus is split into `ad_in`, `ad_out` and a drive enable `ad_oe`.

Programming can only clear bits, and erasing sets every word of the array back to 0xFF. There are two ways to start an erase. One is a high-voltage pin condition. The other is a two-write unlock sequence. An erase runs for a parameterised number of cycles, and `busy` is high while it runs. After any program or erase the block stays in a verify mode, shown on `vmode`, until the synchronous power-down reset `rst_n` returns it to normal read. The array contents survive that reset.

Top module: `mxbus_eeprom`

## Requirements
- R1: The low address byte is taken from `ad_in` at the first clock edge where `ale` is sampled low after being sampled high. The array word used is selected by the low `AW` bits (default 6, 64 words) of that byte. `addr_hi` does not select the word.
- R2: When `oe_n` is low, `ad_oe` is 1 and `ad_out` carries the selected word. When `oe_n` is high, `ad_oe` is 0 and `ad_out` is 0.
- R3: In standby (`ale` and `oe_n` both high), `ad_oe` is 0.
- R4: A write happens on a clock edge where `ale` is sampled rising, `vpp_hi`=1, `vdd_hi`=1, `a9_hv`=0 and `busy`=0. The write stores the old word AND `ad_in`, so it can only turn bits from 1 to 0.
- R5: An erase starts on a rising `ale` edge, with `busy`=0, when `vpp_hi`=1, `a9_hv`=1, `addr_hi[2]`=1, `addr_hi[0]`=0 and `addr_hi[3]`=0. In that case `busy` is 1 in the next cycle. If any of these bits differs, no erase starts.
- R6: A write of 0xAA to full address 0x5555 followed directly by a write of 0x10 to 0x2AAA starts an erase. The full address is {`addr_hi`, latched low byte}.
- R7: Any write other than the expected second one returns the sequence detector to waiting for the first write. A later 0x10-to-0x2AAA write then starts nothing.
- R8: `busy` stays high for exactly `ERASE_CYC` cycles, and all words read 0xFF when it falls. Writes and erase starts while `busy` is high have no effect.
- R9: `vmode` encodes 0 = normal read, 1 = erase verify, 2 = program verify. An erase that finishes gives 1, and a write gives 2. Only `rst_n` low returns it to 0, and that reset leaves the array contents unchanged.
- R10: With `ale` held low, or with `vdd_hi` low on an `ale` pulse, `vpp_hi` and `ad_in` change nothing in the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-down reset |
| ale | input | 1 | Address strobe; its falling edge captures the low address |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Programming voltage present on the output-enable pin |
| vdd_hi | input | 1 | Raised programming supply present |
| a9_hv | input | 1 | High voltage present on address bit 9 |
| addr_hi | input | HI_W | Upper address bits |
| ad_in | input | 8 | Shared bus, value driven by the host |
| ad_out | output | 8 | Shared bus, value driven by the block |
| ad_oe | output | 1 | Block drives the shared bus |
| busy | output | 1 | Erase in progress |
| vmode | output | 2 | Operating mode (see R9) |

## Verification
The assertions assume the host never drives `ale` high while `oe_n` is low, and that `vpp_hi` is never raised while a read is enabled. The write-only-clears property also assumes no word changes outside a write or an erase completion. The bench drives every pin change just after a rising clock edge. It always holds `oe_n` high while it raises the qualifiers, and it opens the output only after the address strobe has fallen. Before the first erase the array contents are not known, so the bench compares read data only once an erase has completed.

// File: rtl/mxe_pkg.sv
// Package: shared mode encoding and unlock-sequence constants for the
// multiplexed-bus memory model. Assumes a 16-bit full address for the
// sequence compare (it is resized to the instance's address width).
package mxe_pkg;

    typedef enum logic [1:0] {
        VM_READ      = 2'd0,
        VM_ERASE_VFY = 2'd1,
        VM_PROG_VFY  = 2'd2
    } vmode_e;

    localparam logic [15:0] SEQ1_ADDR = 16'h5555;
    localparam logic [7:0]  SEQ1_DATA = 8'hAA;
    localparam logic [15:0] SEQ2_ADDR = 16'h2AAA;
    localparam logic [7:0]  SEQ2_DATA = 8'h10;

endpackage

// File: rtl/mxe_addr_latch.sv
// Address strobe edge detection and the low-address register.
// Assumes ale is synchronous to clk. The low byte is taken from the shared
// bus on the sampled high-to-low transition of ale.
module mxe_addr_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ale,
    input  logic [7:0] ad_in,
    output logic       ale_rise,
    output logic [7:0] lo_addr
);
    logic ale_q;
    logic ale_fall;

    // Edges of the strobe against its value at the previous clock edge.
    assign ale_rise = ale & ~ale_q;
    assign ale_fall = ~ale & ale_q;

    // Keep the previous strobe value and capture the low address on a falling strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q   <= 1'b0;
            lo_addr <= 8'h00;
        end else begin
            ale_q <= ale;
            if (ale_fall) lo_addr <= ad_in;
        end
    end

    // R1: the latched byte moves only on a falling strobe.
    a_r1_latch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale_q && !ale) |=> $stable(lo_addr));

endmodule

// File: rtl/mxe_cmd_seq.sv
// Two-write unlock detector for erase entry.
// Assumes wr pulses once per accepted write, with the full address and data
// valid in the same cycle. Any write that is not the expected one disarms.
module mxe_cmd_seq #(
    parameter int FULL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [FULL_W-1:0] full_addr,
    input  logic [7:0]        wdata,
    output logic              seq_hit
);
    import mxe_pkg::*;

    logic armed;
    logic first_ok;
    logic second_ok;

    // Match the write against the two sequence entries.
    assign first_ok  = (full_addr == FULL_W'(SEQ1_ADDR)) && (wdata == SEQ1_DATA);
    assign second_ok = (full_addr == FULL_W'(SEQ2_ADDR)) && (wdata == SEQ2_DATA);
    assign seq_hit   = wr & armed & second_ok;

    // Arm on the first entry; any write while armed returns to waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)  armed <= 1'b0;
        else if (wr) armed <= ~armed & first_ok;
    end

    // R6: arming only follows a first-entry write.
    a_r6_arm_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(wr && first_ok));

    // R7: a write seen while armed always disarms.
    a_r7_break_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && armed) |=> !armed);

endmodule

// File: rtl/mxe_ctrl.sv
// Operation control: decides program and erase starts, times the erase and
// holds the sticky verify mode. Assumes ale_rise is a one-cycle pulse. The
// erase length is ERASE_CYC cycles (at least 1).
module mxe_ctrl #(
    parameter int ERASE_CYC = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ale_rise,
    input  logic                hv_ok,
    input  logic                prog_ok,
    input  logic                seq_hit,
    output logic                busy,
    output logic                prog_en,
    output logic                erase_done,
    output mxe_pkg::vmode_e     mode
);
    import mxe_pkg::*;

    localparam int CNT_W = $clog2(ERASE_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             start;

    // Accepted operations are gated by the strobe edge and by an idle erase timer.
    assign prog_en    = ale_rise & ~busy & prog_ok;
    assign start      = ale_rise & ~busy & (hv_ok | seq_hit);
    assign erase_done = busy & (cnt_q == '0);

    // Erase timer: loaded on start, counted down, released at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(ERASE_CYC - 1);
        end else if (erase_done) begin
            busy  <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Verify mode: set by each completed operation, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          mode <= VM_READ;
        else if (erase_done) mode <= VM_ERASE_VFY;
        else if (prog_en)    mode <= VM_PROG_VFY;
    end

    // R9: once out of normal read, no return without reset.
    a_r9_sticky_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != VM_READ) |=> (mode != VM_READ));

    // R9: the end of an erase leaves erase verify.
    a_r9_erase_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (mode == VM_ERASE_VFY));

    // R8: an erase only begins on a strobe edge.
    a_r8_start_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ale_rise));

endmodule

// File: rtl/mxe_array.sv
// Storage array of 2**AW bytes. Writes AND new data into the selected word,
// and a clear sets every word to 0xFF. The contents have no reset: they model
// non-volatile cells and are undefined until the first erase.
module mxe_array #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  logic          clr_all,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rd_word
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    // Asynchronous read of the addressed word.
    assign rd_word = mem_q[idx];

    // Whole-array erase, or a write that can only clear bits.
    always_ff @(posedge clk) begin
        if (clr_all) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (prog_en) begin
            mem_q[idx] <= mem_q[idx] & wdata;
        end
    end

    // R4: a write never sets a bit that was clear.
    a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !clr_all) |=> ((mem_q[$past(idx)] & ~$past(rd_word)) == 8'h00));

endmodule

// File: rtl/mxbus_eeprom.sv
// Top of the multiplexed-bus reprogrammable byte memory model.
// Assumes all inputs are synchronous to clk and that AW <= 8 and HI_W >= 4.
// The high voltages appear only as the qualifiers vpp_hi, vdd_hi and a9_hv.
module mxbus_eeprom #(
    parameter int HI_W      = 8,
    parameter int AW        = 6,
    parameter int ERASE_CYC = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ale,
    input  logic            oe_n,
    input  logic            vpp_hi,
    input  logic            vdd_hi,
    input  logic            a9_hv,
    input  logic [HI_W-1:0] addr_hi,
    input  logic [7:0]      ad_in,
    output logic [7:0]      ad_out,
    output logic            ad_oe,
    output logic            busy,
    output logic [1:0]      vmode
);
    import mxe_pkg::*;

    localparam int FULL_W = HI_W + 8;

    logic              ale_rise;
    logic [7:0]        lo_addr;
    logic [FULL_W-1:0] full_addr;
    logic              hv_ok;
    logic              prog_ok;
    logic              seq_hit;
    logic              prog_en;
    logic              erase_done;
    logic [7:0]        rd_word;
    vmode_e            mode;

    // Qualifier decode for the pin-level erase and for writes.
    assign full_addr = {addr_hi, lo_addr};
    assign hv_ok     = vpp_hi & a9_hv & addr_hi[2] & ~addr_hi[0] & ~addr_hi[3];
    assign prog_ok   = vpp_hi & vdd_hi & ~a9_hv;

    // Output path: the bus is driven only while output enable is low.
    assign ad_oe  = ~oe_n;
    assign ad_out = ad_oe ? rd_word : 8'h00;
    assign vmode  = mode;

    mxe_addr_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (ale),
        .ad_in    (ad_in),
        .ale_rise (ale_rise),
        .lo_addr  (lo_addr)
    );

    mxe_cmd_seq #(.FULL_W(FULL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (prog_en),
        .full_addr (full_addr),
        .wdata     (ad_in),
        .seq_hit   (seq_hit)
    );

    mxe_ctrl #(.ERASE_CYC(ERASE_CYC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ale_rise   (ale_rise),
        .hv_ok      (hv_ok),
        .prog_ok    (prog_ok),
        .seq_hit    (seq_hit),
        .busy       (busy),
        .prog_en    (prog_en),
        .erase_done (erase_done),
        .mode       (mode)
    );

    mxe_array #(.AW(AW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog_en (prog_en),
        .clr_all (erase_done),
        .idx     (lo_addr[AW-1:0]),
        .wdata   (ad_in),
        .rd_word (rd_word)
    );

    // R3: standby never drives the bus.
    a_r3_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && oe_n) |-> !ad_oe);

    // R8: the addressed word reads erased when the erase ends.
    a_r8_erased_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (rd_word == 8'hFF));

endmodule

// File: tb/mxbus_eeprom_tb.sv
`timescale 1ns/1ps
module mxbus_eeprom_tb;
    localparam int ECYC  = 20;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale = 1'b0, oe_n = 1'b1, vpp_hi = 1'b0, vdd_hi = 1'b0, a9_hv = 1'b0;
    logic [7:0] addr_hi = 8'h00, ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe, busy;
    logic [1:0] vmode;

    int total = 0, fails = 0;
    bit cmp_en = 1'b0, done_flag = 1'b0;

    // Reference model state.
    int  m_mem [DEPTH];
    bit  m_known = 1'b0;
    bit  m_ale_q, m_busy, m_armed;
    int  m_lo, m_cnt, m_mode;

    always #10 clk = ~clk;

    mxbus_eeprom #(.ERASE_CYC(ECYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .vdd_hi(vdd_hi), .a9_hv(a9_hv), .addr_hi(addr_hi), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .busy(busy), .vmode(vmode)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference, stepped on every rising edge.
    always @(posedge clk) begin
        bit rise, fall, hv, pc, wr, b0;
        int full;
        if (!rst_n) begin
            m_ale_q = 0; m_lo = 0; m_busy = 0; m_cnt = 0; m_armed = 0; m_mode = 0;
        end else begin
            rise = ale && !m_ale_q;
            fall = !ale && m_ale_q;
            full = {addr_hi, m_lo[7:0]};
            hv   = vpp_hi && a9_hv && addr_hi[2] && !addr_hi[0] && !addr_hi[3];
            pc   = vpp_hi && vdd_hi && !a9_hv;
            b0   = m_busy;
            wr   = rise && !b0 && pc;
            if (b0) begin
                if (m_cnt == 0) begin
                    foreach (m_mem[i]) m_mem[i] = 'hFF;
                    m_known = 1; m_mode = 1; m_busy = 0;
                end else m_cnt--;
            end
            if (wr) begin
                m_mem[m_lo % DEPTH] = m_mem[m_lo % DEPTH] & ad_in;
                m_mode = 2;
            end
            if (rise && !b0 && (hv || (wr && m_armed && full == 'h2AAA && ad_in == 8'h10))) begin
                m_busy = 1; m_cnt = ECYC - 1;
            end
            if (wr) m_armed = !m_armed && full == 'h5555 && ad_in == 8'hAA;
            if (fall) m_lo = ad_in;
            m_ale_q = ale;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && !done_flag) begin
            chk("R2 drive enable", ad_oe, !oe_n);
            chk("R8 busy", busy, m_busy);
            chk("R9 mode", vmode, m_mode);
            if (oe_n) chk("R2 idle bus value", ad_out, 0);
            else if (m_known) chk("R2 read data", ad_out, m_mem[m_lo % DEPTH]);
        end
    end

    task automatic step(); @(posedge clk); #2; endtask

    task automatic latch(int a);
        addr_hi = a[15:8]; ad_in = a[7:0]; ale = 1; step(); ale = 0; step();
    endtask

    task automatic wr(int a, int d);
        latch(a);
        ad_in = d[7:0]; oe_n = 1; vpp_hi = 1; vdd_hi = 1; ale = 1; step();
        ale = 0; step(); vpp_hi = 0; vdd_hi = 0;
    endtask

    task automatic rd(int a, int exp, string tag);
        latch(a); oe_n = 0; @(negedge clk); chk(tag, ad_out, exp); step(); oe_n = 1;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; step(); end
    endtask

    initial begin
        int n;
        repeat (3) step();
        rst_n = 1; cmp_en = 1; step();
        chk("R9 reset mode", vmode, 0);
        chk("R8 reset busy", busy, 0);
        chk("R3 reset bus released", ad_oe, 0);

        // Pin-condition erase.
        addr_hi = 8'h04; vpp_hi = 1; a9_hv = 1; oe_n = 1; ale = 1; step();
        chk("R5 high-voltage erase starts", busy, 1);
        ale = 0; vpp_hi = 0; a9_hv = 0;
        wait_idle(n);
        chk("R8 erase length", n, ECYC);
        chk("R9 erase verify", vmode, 1);
        rd('h0000, 'hFF, "R8 erased word 0");
        rd('h003F, 'hFF, "R8 erased last word");

        // Writes only clear bits.
        wr('h0005, 'h3C);
        chk("R9 program verify", vmode, 2);
        rd('h0005, 'h3C, "R4 first write");
        wr('h0005, 'hF0);
        rd('h0005, 'h30, "R4 second write ANDs");
        rd('h0105, 'h30, "R1 upper bits do not select word");
        rd('h0006, 'hFF, "R1 neighbour untouched");

        // Inhibit: strobe held low.
        latch('h0005); vpp_hi = 1; vdd_hi = 1;
        ad_in = 8'h00; repeat (5) step(); vpp_hi = 0; vdd_hi = 0;
        rd('h0005, 'h30, "R10 strobe low inhibits");
        // Pulse without raised supply.
        latch('h0006); ad_in = 8'h00; vpp_hi = 1; ale = 1; step(); ale = 0; step(); vpp_hi = 0;
        rd('h0006, 'hFF, "R10 no supply no write");

        // Pin erase with A8 high must not start.
        addr_hi = 8'h05; vpp_hi = 1; a9_hv = 1; ale = 1; step(); ale = 0; step();
        vpp_hi = 0; a9_hv = 0;
        chk("R5 wrong pin condition", busy, 0);

        // Standby.
        ale = 1; oe_n = 1; @(negedge clk);
        chk("R3 standby bus released", ad_oe, 0);
        step(); ale = 0; step();

        // Power-down reset keeps contents.
        rst_n = 0; repeat (2) step(); rst_n = 1; step();
        chk("R9 reset to normal", vmode, 0);
        rd('h0005, 'h30, "R9 contents survive reset");

        // Broken sequence.
        wr('h5555, 'hAA); wr('h1234, 'h55); wr('h2AAA, 'h10);
        repeat (3) step();
        chk("R7 broken sequence no erase", busy, 0);
        rd('h0034, 'h55, "R4 breaking write stored");

        // Correct sequence.
        wr('h5555, 'hAA); wr('h2AAA, 'h10);
        chk("R6 sequence starts erase", busy, 1);
        wr('h0001, 'h00);
        wait_idle(n);
        chk("R9 erase verify after sequence", vmode, 1);
        rd('h0001, 'hFF, "R8 write during erase ignored");
        rd('h0005, 'hFF, "R6 array erased");

        done_flag = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done_flag) begin
            done_flag = 1;
            total++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule